// File: doc/BRIEF.md
# Register-Driven Management Interface Master

This block drives a two-wire management bus (a clock line plus one bidirectional data line) for a host that only has a simple register bus. The host programs a control register with the serial clock divisor and a preamble enable, then writes a packed 32-bit command word to a data/command register. If the start bit is set, the block sends the word most significant bit first as a management frame. The word holds the start code, opcode, device, register, turnaround and 16 data bits. An optional run of 32 ones comes first.

For a read, the block lets go of the data line from the turnaround onwards. It samples the 16 returned bits and places them in the low half of the data register. A completion flag and a busy flag can be read from the control register. A strap input selects the addressing layout. In the legacy layout the device number travels inside the access frame. In the extended layout the block first sends its own device-select write frame. It then sends the access frame, with the device field cleared, straight after.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads 0, the serial clock is low and the data line is released (output enable low).
- R2: The control register sits at byte address 0x128 and the data/command register at 0x12C. In the control register, bits 6:0 hold the divisor, bit 7 enables the preamble, bit 8 is the done flag and bit 9 the busy flag. A data-register write while idle stores the word, and it starts a frame only when bit 30 of the word is 1.
- R3: The serial clock is low when idle. It goes high divisor+1 clocks after the command is accepted, and then toggles every divisor+1 clocks while busy.
- R4: A frame is 32 ones when the preamble is enabled, followed by command bits 31 down to 0. The data line changes only while the serial clock is low.
- R5: A command with bit 29 = 1 and bit 28 = 0 is a read. The output enable is low for command bit positions 17 down to 0. Sixteen bits are sampled on rising clock edges, first bit to bit 15. At the end they replace the data register, with bits 31:16 zero.
- R6: At the last falling edge of a transfer, busy clears and done sets. Done stays set until the next start or a control clear, and it is never set while busy.
- R7: With the extended strap high, a started command first sends the word 0x5000_0000 | (0x1F << 18) | (1 << 17) | (P << 4), where P is taken from command bits 27:23. The access frame, with bits 27:23 forced to 0, follows with no gap, each frame with its own preamble.
- R8: A data-register write while busy changes neither the data register nor the frame in flight.
- R9: Writing 0 to the control register ends the transfer at once. Busy and done clear, the serial clock goes low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | Strap: 1 selects the extended layout with a separate device-select frame |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions take for granted that the layout strap holds still while a transfer is in flight. They also assume that a register write and the end of a frame do not target the data register in the same cycle in any way other than the ignored busy write. The stimulus changes the strap only while the block is idle. It issues one bus write per cycle at most, and it drives the returned data line only during the bit times that the reference model marks as released. It keeps that value stable across each sampling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W        = 32;
  localparam int DATA_W       = 16;
  localparam int DIV_W        = 7;
  localparam int PRE_LEN      = 32;
  // control register fields
  localparam int CTL_PRE_BIT  = 7;
  localparam int CTL_DONE_BIT = 8;
  localparam int CTL_BUSY_BIT = 9;
  // command word fields
  localparam int CMD_GO_BIT   = 30;
  localparam int CMD_RD_BIT   = 29;
  localparam int CMD_WR_BIT   = 28;
  localparam int CMD_TA_BIT   = 17;
  localparam int DEV_LSB      = 23;
  localparam int DEV_W        = 5;
  localparam int REG_LSB      = 18;
  localparam int SEL_DEV_LSB  = 4;
  localparam logic [4:0] SEL_REG = 5'h1F;

  function automatic logic [CMD_W-1:0] dev_select_word(logic [DEV_W-1:0] dev);
    logic [CMD_W-1:0] w;
    w = '0;
    w[CMD_GO_BIT] = 1'b1;
    w[CMD_WR_BIT] = 1'b1;
    w[CMD_TA_BIT] = 1'b1;
    w[REG_LSB +: 5] = SEL_REG;
    w[SEL_DEV_LSB +: DEV_W] = dev;
    return w;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [DW-1:0] div,
  output logic          mdc,
  output logic          rise,
  output logic          fall
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick  = run && (cnt_q == div);
    rise  = tick && !mdc_q;
    fall  = tick && mdc_q;
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run || clr) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R3
  mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr) |=> mdc);
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_pkg::*;
#(
  parameter int W   = 32,
  parameter int PL  = 32,
  parameter int DWD = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   frame_in,
  input  logic           pre_en,
  input  logic           clr,
  input  logic           rise,
  input  logic           fall,
  input  logic           mdio_i,
  output logic           active,
  output logic           rd_mode,
  output logic           end_p,
  output logic           mdio_o,
  output logic           mdio_oe,
  output logic [DWD-1:0] rd_word
);
  localparam int IDX_W = $clog2(W + PL + 1);
  localparam int POS_W = $clog2(W);
  localparam logic [IDX_W-1:0] TOP_FRM = IDX_W'(W - 1);
  localparam logic [IDX_W-1:0] TOP_PRE = IDX_W'(W + PL - 1);
  localparam logic [IDX_W-1:0] FRM_LIM = IDX_W'(W);
  localparam logic [IDX_W-1:0] REL_LIM = IDX_W'(DWD + 2);
  localparam logic [IDX_W-1:0] SMP_LIM = IDX_W'(DWD);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     frm_q, frm_d;
  logic [DWD-1:0]   rd_q, rd_d;
  logic             in_pre, sample;

  always_comb begin
    rd_mode = frm_q[CMD_RD_BIT] & ~frm_q[CMD_WR_BIT];
    in_pre  = idx_q >= FRM_LIM;
    mdio_o  = (!act_q || in_pre) ? 1'b1 : frm_q[idx_q[POS_W-1:0]];
    mdio_oe = act_q && !(rd_mode && (idx_q < REL_LIM));
    end_p   = act_q && fall && (idx_q == '0);
    sample  = act_q && rise && rd_mode && (idx_q < SMP_LIM);
  end

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    frm_d = frm_q;
    rd_d  = rd_q;
    if (clr) begin
      act_d = 1'b0;
    end else if (load) begin
      act_d = 1'b1;
      idx_d = pre_en ? TOP_PRE : TOP_FRM;
      frm_d = frame_in;
      rd_d  = '0;
    end else if (end_p) begin
      act_d = 1'b0;
    end else if (fall && act_q) begin
      idx_d = idx_q - 1'b1;
    end
    if (sample && !clr && !load)
      rd_d = {rd_q[DWD-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      frm_q <= '0;
      rd_q  <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      frm_q <= frm_d;
      rd_q  <= rd_d;
    end
  end

  assign active  = act_q;
  assign rd_word = rd_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h128,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 12'h12C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ext,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              rst_meta, rst_n_int;
  logic              pre_q, pre_d, done_q, done_d, pend_q, pend_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CMD_W-1:0]  data_q, data_d, acc_q, acc_d, load_frame;
  logic              ctrl_wr, data_wr, abort, start, load, busy;
  logic              rise, fall, sh_end, sh_rd;
  logic [DATA_W-1:0] rd_word;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  always_comb begin
    ctrl_wr = reg_we && (reg_addr == CTRL_ADDR);
    data_wr = reg_we && (reg_addr == DATA_ADDR);
    abort   = ctrl_wr && (reg_wdata == '0);
    start   = data_wr && !busy && reg_wdata[CMD_GO_BIT];
    load    = start || (sh_end && pend_q && !abort);
    if (start)
      load_frame = mode_ext ? dev_select_word(reg_wdata[DEV_LSB +: DEV_W]) : reg_wdata;
    else
      load_frame = acc_q;
  end

  always_comb begin
    pre_d  = pre_q;
    div_d  = div_q;
    done_d = done_q;
    pend_d = pend_q;
    data_d = data_q;
    acc_d  = acc_q;
    if (ctrl_wr && (!busy || abort)) begin
      pre_d = reg_wdata[CTL_PRE_BIT];
      div_d = reg_wdata[DIV_W-1:0];
    end
    if (abort) begin
      done_d = 1'b0;
      pend_d = 1'b0;
    end else if (start) begin
      done_d = 1'b0;
      pend_d = mode_ext;
      acc_d  = reg_wdata;
      acc_d[DEV_LSB +: DEV_W] = '0;
    end else if (sh_end) begin
      if (pend_q) begin
        pend_d = 1'b0;
      end else begin
        done_d = 1'b1;
        if (sh_rd)
          data_d = {{(CMD_W-DATA_W){1'b0}}, rd_word};
      end
    end
    if (data_wr && !busy)
      data_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pre_q  <= 1'b0;
      div_q  <= '0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
      data_q <= '0;
      acc_q  <= '0;
    end else begin
      pre_q  <= pre_d;
      div_q  <= div_d;
      done_q <= done_d;
      pend_q <= pend_d;
      data_q <= data_d;
      acc_q  <= acc_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[DIV_W-1:0]    = div_q;
      reg_rdata[CTL_PRE_BIT]  = pre_q;
      reg_rdata[CTL_DONE_BIT] = done_q;
      reg_rdata[CTL_BUSY_BIT] = busy;
    end else if (reg_addr == DATA_ADDR) begin
      reg_rdata = data_q;
    end
  end

  mdio_clk_div #(.DW(DIV_W)) clk_div_i (
    .clk(clk), .rst_n(rst_n_int), .run(busy), .clr(abort), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_shift #(.W(CMD_W), .PL(PRE_LEN), .DWD(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n_int), .load(load), .frame_in(load_frame),
    .pre_en(pre_q), .clr(abort), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .active(busy), .rd_mode(sh_rd), .end_p(sh_end), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_word(rd_word)
  );

  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> (!mdc && !mdio_oe));
  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy |-> !done_q);
  // R8
  busy_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (data_wr && busy && !sh_end) |=> (data_q == $past(data_q)));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    abort |=> (!busy && !done_q && !mdc));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h128;
  localparam logic [11:0] A_DATA = 12'h12C;

  logic        clk, rst_n, mode_ext, reg_we, mdio_i;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit wd_hit = 0;

  // reference model state
  bit   m_on = 0, m_done = 0, m_pre = 0;
  int   m_t = 0, m_total = 0, m_half = 1, m_nb = 0;
  bit   eo[256], eoe[256], ein[256];
  bit   m_rd = 0;
  logic [15:0] m_rv = '0;
  logic [31:0] m_data = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add_frame(logic [31:0] f, bit pre, logic [15:0] rv);
    bit rd;
    rd = f[29] && !f[28];
    if (pre) for (int i = 0; i < 32; i++) begin
      eo[m_nb] = 1; eoe[m_nb] = 1; ein[m_nb] = 0; m_nb++;
    end
    for (int p = 31; p >= 0; p--) begin
      eo[m_nb]  = f[p];
      eoe[m_nb] = !(rd && p <= 17);
      ein[m_nb] = (rd && p <= 15) ? rv[p] : 1'b0;
      m_nb++;
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      if (m_on) begin
        m_t++;
        if (m_t >= m_total) begin
          m_on = 0;
          m_done = 1;
          if (m_rd) m_data = {16'h0, m_rv};
        end
      end
      if (m_on) begin
        int b;
        b = m_t / (2 * m_half);
        chk("R3 mdc", {31'b0, mdc}, {31'b0, 1'((m_t / m_half) % 2)});
        chk("R5 oe", {31'b0, mdio_oe}, {31'b0, eoe[b]});
        if (eoe[b]) chk("R4 bit", {31'b0, mdio_o}, {31'b0, eo[b]});
        mdio_i = ein[b];
      end else begin
        chk("R3 idle mdc", {31'b0, mdc}, 32'h0);
        chk("R3 idle oe", {31'b0, mdio_oe}, 32'h0);
        mdio_i = 1'b0;
      end
      if (!reg_we && reg_addr == A_CTRL) begin
        chk("R6 busy", {31'b0, reg_rdata[9]}, {31'b0, m_on});
        chk("R6 done", {31'b0, reg_rdata[8]}, {31'b0, m_done});
      end
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0; reg_addr = A_CTRL;
  endtask

  task automatic set_ctrl(logic [31:0] v);
    bus_wr(A_CTRL, v);
    m_half = int'(v[6:0]) + 1;
    m_pre  = v[7];
  endtask

  task automatic start_cmd(logic [31:0] d, logic [15:0] rv);
    bus_wr(A_DATA, d);
    m_nb = 0;
    if (mode_ext) begin
      add_frame(32'h5000_0000 | (32'h1F << 18) | 32'h2_0000 | ({27'b0, d[27:23]} << 4), m_pre, 16'h0);
      add_frame(d & ~(32'h1F << 23), m_pre, rv);
    end else begin
      add_frame(d, m_pre, rv);
    end
    m_rd = d[29] && !d[28];
    m_rv = rv;
    m_data = d;
    m_done = 0;
    m_t = -1;
    m_total = m_nb * 2 * m_half;
    m_on = 1;
  endtask

  task automatic wait_idle();
    while (m_on) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk); #1;
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
    reg_addr = A_CTRL;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    rst_n = 0; mode_ext = 0; reg_we = 0; reg_addr = A_CTRL; reg_wdata = '0; mdio_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd_chk(A_CTRL, 32'h0, "R1 ctrl");
    chk("R1 mdc", {31'b0, mdc}, 32'h0);
    chk("R1 oe", {31'b0, mdio_oe}, 32'h0);

    // legacy write frame with preamble, divisor 2
    set_ctrl(32'h82);
    start_cmd(32'h5000_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'h2_0000 | 32'hBEEF, 16'h0);
    wait_idle();
    rd_chk(A_CTRL, 32'h182, "R6 done after write");
    rd_chk(A_DATA, m_data, "R2 data keeps command");

    // legacy read, no preamble, divisor 1
    set_ctrl(32'h01);
    start_cmd(32'h6000_0000 | (32'd2 << 23) | (32'd1 << 18) | 32'h2_0000 | 32'h1234, 16'hA5C3);
    wait_idle();
    rd_chk(A_DATA, 32'h0000_A5C3, "R5 read capture");

    // write while busy is ignored
    set_ctrl(32'h82);
    start_cmd(32'h5000_0000 | (32'd7 << 23) | (32'd4 << 18) | 32'h2_0000 | 32'h0F0F, 16'h0);
    repeat (20) @(negedge clk);
    bus_wr(A_DATA, 32'h6FFF_FFFF);
    wait_idle();
    rd_chk(A_DATA, 32'h5000_0000 | (32'd7 << 23) | (32'd4 << 18) | 32'h2_0000 | 32'h0F0F, "R8 busy write ignored");

    // control clear while idle drops done
    bus_wr(A_CTRL, 32'h0);
    m_done = 0; m_half = 1; m_pre = 0;
    rd_chk(A_CTRL, 32'h0, "R9 clear done");

    // word without start bit is stored only
    bus_wr(A_DATA, 32'h0000_1234);
    m_data = 32'h0000_1234;
    repeat (10) @(negedge clk);
    rd_chk(A_DATA, 32'h0000_1234, "R2 stored no start");
    rd_chk(A_CTRL, 32'h0, "R2 no frame started");

    // extended layout read
    mode_ext = 1;
    set_ctrl(32'h81);
    start_cmd(32'h6000_0000 | (32'd9 << 23) | (32'd2 << 18) | 32'h2_0000, 16'h3C96);
    wait_idle();
    rd_chk(A_DATA, 32'h0000_3C96, "R7 ext read data");

    // extended layout write, larger divisor
    set_ctrl(32'h05);
    start_cmd(32'h5000_0000 | (32'd17 << 23) | (32'd6 << 18) | 32'h2_0000 | 32'h7E81, 16'h0);
    wait_idle();
    rd_chk(A_CTRL, 32'h105, "R7 ext write done");

    // abort mid-frame
    mode_ext = 0;
    set_ctrl(32'h82);
    start_cmd(32'h5000_0000 | (32'd1 << 23) | (32'd1 << 18) | 32'h2_0000 | 32'h5555, 16'h0);
    repeat (50) @(negedge clk);
    bus_wr(A_CTRL, 32'h0);
    m_on = 0; m_done = 0; m_half = 1; m_pre = 0;
    repeat (5) @(negedge clk);
    rd_chk(A_CTRL, 32'h0, "R9 abort ctrl");
    chk("R9 abort mdc", {31'b0, mdc}, 32'h0);
    chk("R9 abort oe", {31'b0, mdio_oe}, 32'h0);

    // fresh read after abort
    set_ctrl(32'h02);
    start_cmd(32'h6000_0000 | (32'd3 << 23) | (32'd8 << 18) | 32'h2_0000, 16'h8001);
    wait_idle();
    rd_chk(A_DATA, 32'h0000_8001, "R5 read after abort");
    repeat (5) @(negedge clk);
    summary();
  end
endmodule